// File: doc/BRIEF.md
# RGB Dot-Clock Scan Generator

This block scans a parallel RGB panel in dot-clock mode over an 8-bit data bus. It makes a dot clock at half the system clock. It also makes active-low horizontal and vertical sync strobes. Pixel bytes come from a valid/ready byte FIFO that a DMA engine keeps filled. Each pixel takes three dot clocks, sent red, green, blue. The line and frame geometry (sync width, back porch, visible size, front porch) is set by parameters. The defaults are a 320 x 240 panel with an 8-dot / 24-dot / 4-dot line and a 1 / 3 / 1-line frame.

Software starts the scan with a one-cycle start strobe. A stop strobe leaves scan mode at once. The block then drains and discards whatever the FIFO still holds, and only then reports itself idle.

If the FIFO is empty when a visible byte is due, the frame is abandoned. The block leaves scan mode for one cycle, pulses a FIFO flush and sets a sticky underflow flag. It then starts a fresh frame from the first sync dot, which gives the DMA the whole sync and back-porch time to refill. A one-cycle frame event marks the start of every frame, so software can count whole frames.

Top module: `pix_scan_gen`

## Requirements
- R1: After reset, and whenever idle, hsync_n and vsync_n are 1, and dotclk_out, pix_data, fifo_ready, fifo_flush, frame_evt, busy and urun_flag are 0.
- R2: While scanning, dotclk_out has a period of two clock cycles. It is low in the first cycle after a frame starts. The sync and data outputs change only together with a falling edge of dotclk_out, so each dot lasts two cycles.
- R3: A line is H_SYNC + H_BACK + 3*H_PIX + H_FRONT dots long. hsync_n is 0 for the first H_SYNC dots of each line and 1 for the rest.
- R4: A frame is V_SYNC + V_BACK + V_LINES + V_FRONT lines long. vsync_n is 0 for the whole of the first V_SYNC lines and 1 for the rest.
- R5: A dot is visible when its line index lies in [V_SYNC+V_BACK, V_SYNC+V_BACK+V_LINES) and its dot index in the line lies in [H_SYNC+H_BACK, H_SYNC+H_BACK+3*H_PIX). Each visible dot shows the next FIFO byte, in FIFO order. Every group of three bytes is one pixel, sent red, then green, then blue.
- R6: On dots that are not visible, pix_data is 0 and no FIFO byte is taken. An empty FIFO on such dots has no effect.
- R7: If the FIFO is empty when a visible byte is due, then from the next cycle the block is out of scan mode for exactly one cycle. In that cycle both syncs are 1, dotclk_out and pix_data are 0, and fifo_flush is 1. In the cycle after that, a new frame begins at dot 0 of line 0.
- R8: urun_flag becomes 1 with each underflow and stays 1 until urun_clr is 1 for a cycle with no underflow. After that cycle it reads 0.
- R9: frame_evt is a one-cycle pulse in the first cycle of every frame, including a frame started by start_req and one started after an underflow.
- R10: stop_req takes effect at the next cycle: scan mode ends (both syncs 1, dotclk_out 0) and busy stays 1. While the FIFO holds bytes, fifo_ready is 1 and one byte is discarded per cycle. busy falls in the cycle after the FIFO is first seen empty. stop_req wins over start_req.
- R11: start_req while idle begins a frame in the next cycle, with busy 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the dot rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-cycle strobe that starts scanning from idle |
| stop_req | input | 1 | One-cycle strobe that ends scanning and drains the FIFO |
| fifo_data | input | DW | Byte at the head of the pixel FIFO |
| fifo_valid | input | 1 | FIFO holds at least one byte |
| fifo_ready | output | 1 | Head byte is taken at this clock edge |
| fifo_flush | output | 1 | Clear request to the FIFO after an underflow |
| dotclk_out | output | 1 | Dot clock to the panel; data changes on its falling edge |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| pix_data | output | DW | Pixel byte bus |
| frame_evt | output | 1 | One-cycle pulse at each frame start |
| urun_flag | output | 1 | Sticky underflow indication |
| urun_clr | input | 1 | Write-one-to-clear for urun_flag |
| busy | output | 1 | Block is scanning, recovering or draining |

## Verification
The bench builds the block as a 4 x 3 pixel panel with a 2/3/4-dot line and a 1/2/1-line frame. That makes a 21-dot line and a 147-dot frame, so whole frames and their wrap can be swept cycle by cycle. Every dot's sync levels, byte value and FIFO take count are computed from its line and dot index. The small size also lets underflow be forced at the very first visible byte and again just past a line's end, and lets the stop drain be observed with zero and with several bytes left.

// File: rtl/pix_scan_pkg.sv
package pix_scan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_HOLD  = 2'd2,
    ST_DRAIN = 2'd3
  } scan_state_e;

endpackage

// File: rtl/scan_pos_cnt.sv
module scan_pos_cnt #(
  parameter int H_SYNC  = 8,
  parameter int H_BACK  = 24,
  parameter int H_DOTS  = 960,
  parameter int H_FRONT = 4,
  parameter int V_SYNC  = 1,
  parameter int V_BACK  = 3,
  parameter int V_LINES = 240,
  parameter int V_FRONT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic adv,
  output logic sync_h,
  output logic sync_v,
  output logic nxt_active,
  output logic nxt_origin
);

  localparam int H_TOT = H_SYNC + H_BACK + H_DOTS + H_FRONT;
  localparam int V_TOT = V_SYNC + V_BACK + V_LINES + V_FRONT;
  localparam int HCW   = $clog2(H_TOT);
  localparam int VCW   = (V_TOT > 1) ? $clog2(V_TOT) : 1;

  localparam logic [HCW-1:0] H_LAST   = HCW'(H_TOT - 1);
  localparam logic [HCW-1:0] H_SY_END = HCW'(H_SYNC);
  localparam logic [HCW-1:0] H_ACT_LO = HCW'(H_SYNC + H_BACK);
  localparam logic [HCW-1:0] H_ACT_HI = HCW'(H_SYNC + H_BACK + H_DOTS);
  localparam logic [VCW-1:0] V_LAST   = VCW'(V_TOT - 1);
  localparam logic [VCW-1:0] V_SY_END = VCW'(V_SYNC);
  localparam logic [VCW-1:0] V_ACT_LO = VCW'(V_SYNC + V_BACK);
  localparam logic [VCW-1:0] V_ACT_HI = VCW'(V_SYNC + V_BACK + V_LINES);

  logic [HCW-1:0] h_q, h_d, h_inc;
  logic [VCW-1:0] v_q, v_d, v_inc;

  // Position of the following dot, used as lookahead for byte fetch.
  always_comb begin
    if (h_q == H_LAST) begin
      h_inc = '0;
      v_inc = (v_q == V_LAST) ? '0 : v_q + 1'b1;
    end else begin
      h_inc = h_q + 1'b1;
      v_inc = v_q;
    end
    nxt_active = (h_inc >= H_ACT_LO) && (h_inc < H_ACT_HI) &&
                 (v_inc >= V_ACT_LO) && (v_inc < V_ACT_HI);
    nxt_origin = (h_inc == '0) && (v_inc == '0);
  end

  always_comb begin
    h_d = h_q;
    v_d = v_q;
    if (restart) begin
      h_d = '0;
      v_d = '0;
    end else if (adv) begin
      h_d = h_inc;
      v_d = v_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else begin
      h_q <= h_d;
      v_q <= v_d;
    end
  end

  assign sync_h = (h_q < H_SY_END);
  assign sync_v = (v_q < V_SY_END);

endmodule

// File: rtl/scan_ctrl_fsm.sv
module scan_ctrl_fsm
  import pix_scan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_req,
  input  logic        stop_req,
  input  logic        need_byte,
  input  logic        fifo_valid,
  output scan_state_e state_q,
  output scan_state_e state_d,
  output logic        phase_q,
  output logic        tick,
  output logic        restart,
  output logic        want_byte,
  output logic        urun_evt
);

  logic phase_d;

  always_comb begin
    tick      = (state_q == ST_SCAN) && phase_q;
    want_byte = tick && !stop_req && need_byte;
    urun_evt  = want_byte && !fifo_valid;
    state_d   = state_q;
    restart   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_req && !stop_req) begin
          state_d = ST_SCAN;
          restart = 1'b1;
        end
      end
      ST_SCAN: begin
        if (stop_req)      state_d = ST_DRAIN;
        else if (urun_evt) state_d = ST_HOLD;
      end
      ST_HOLD: begin
        if (stop_req) begin
          state_d = ST_DRAIN;
        end else begin
          state_d = ST_SCAN;
          restart = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (!fifo_valid) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    phase_d = (state_q == ST_SCAN && state_d == ST_SCAN) ? !phase_q : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/scan_byte_path.sv
module scan_byte_path
  import pix_scan_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  scan_state_e   state_d,
  input  logic          restart,
  input  logic          tick,
  input  logic          nxt_active,
  input  logic          nxt_origin,
  input  logic          urun_evt,
  input  logic          urun_clr,
  input  logic [DW-1:0] fifo_data,
  output logic [DW-1:0] pix_data,
  output logic          frame_evt,
  output logic          urun_flag
);

  logic [DW-1:0] data_q, data_d;
  logic          evt_q, evt_d;
  logic          flag_q, flag_d;

  always_comb begin
    data_d = data_q;
    if (state_d != ST_SCAN || restart) begin
      data_d = '0;
    end else if (tick) begin
      data_d = nxt_active ? fifo_data : '0;
    end
    evt_d = (state_d == ST_SCAN) && (restart || (tick && nxt_origin));
    if (urun_evt)      flag_d = 1'b1;
    else if (urun_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      evt_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      data_q <= data_d;
      evt_q  <= evt_d;
      flag_q <= flag_d;
    end
  end

  assign pix_data  = data_q;
  assign frame_evt = evt_q;
  assign urun_flag = flag_q;

endmodule

// File: rtl/pix_scan_gen.sv
module pix_scan_gen
  import pix_scan_pkg::*;
#(
  parameter int DW            = 8,
  parameter int BYTES_PER_PIX = 3,
  parameter int H_PIX         = 320,
  parameter int H_SYNC        = 8,
  parameter int H_BACK        = 24,
  parameter int H_FRONT       = 4,
  parameter int V_LINES       = 240,
  parameter int V_SYNC        = 1,
  parameter int V_BACK        = 3,
  parameter int V_FRONT       = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic          stop_req,
  input  logic [DW-1:0] fifo_data,
  input  logic          fifo_valid,
  output logic          fifo_ready,
  output logic          fifo_flush,
  output logic          dotclk_out,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic [DW-1:0] pix_data,
  output logic          frame_evt,
  output logic          urun_flag,
  input  logic          urun_clr,
  output logic          busy
);

  localparam int H_DOTS = H_PIX * BYTES_PER_PIX;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  scan_state_e state_q, state_d;
  logic phase_q, tick, restart, want_byte, urun_evt;
  logic sync_h, sync_v, nxt_active, nxt_origin;

  scan_ctrl_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .start_req  (start_req),
    .stop_req   (stop_req),
    .need_byte  (nxt_active),
    .fifo_valid (fifo_valid),
    .state_q    (state_q),
    .state_d    (state_d),
    .phase_q    (phase_q),
    .tick       (tick),
    .restart    (restart),
    .want_byte  (want_byte),
    .urun_evt   (urun_evt)
  );

  scan_pos_cnt #(
    .H_SYNC  (H_SYNC),
    .H_BACK  (H_BACK),
    .H_DOTS  (H_DOTS),
    .H_FRONT (H_FRONT),
    .V_SYNC  (V_SYNC),
    .V_BACK  (V_BACK),
    .V_LINES (V_LINES),
    .V_FRONT (V_FRONT)
  ) u_pos (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .restart    (restart),
    .adv        (tick),
    .sync_h     (sync_h),
    .sync_v     (sync_v),
    .nxt_active (nxt_active),
    .nxt_origin (nxt_origin)
  );

  scan_byte_path #(.DW(DW)) u_bytes (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .state_d    (state_d),
    .restart    (restart),
    .tick       (tick),
    .nxt_active (nxt_active),
    .nxt_origin (nxt_origin),
    .urun_evt   (urun_evt),
    .urun_clr   (urun_clr),
    .fifo_data  (fifo_data),
    .pix_data   (pix_data),
    .frame_evt  (frame_evt),
    .urun_flag  (urun_flag)
  );

  assign fifo_ready = want_byte || (state_q == ST_DRAIN);
  assign fifo_flush = (state_q == ST_HOLD);
  assign dotclk_out = (state_q == ST_SCAN) && phase_q;
  assign hsync_n    = !((state_q == ST_SCAN) && sync_h);
  assign vsync_n    = !((state_q == ST_SCAN) && sync_v);
  assign busy       = (state_q != ST_IDLE);

endmodule

// File: rtl/scan_gen_chk.sv
module scan_gen_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stop_req,
  input logic          fifo_ready,
  input logic          fifo_flush,
  input logic          dotclk_out,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic [DW-1:0] pix_data,
  input logic          frame_evt,
  input logic          urun_flag,
  input logic          urun_clr,
  input logic          busy
);

  assert_dot_low_after_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dotclk_out |=> !dotclk_out);

  assert_hold_during_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dotclk_out |-> ($stable(hsync_n) && $stable(vsync_n) && $stable(pix_data)));

  assert_sync_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n |-> (pix_data == '0));

  assert_no_take_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fifo_ready);

  assert_flush_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_flush && !stop_req) |=> (frame_evt && !fifo_flush));

  assert_flag_with_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> urun_flag);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (urun_flag && !urun_clr) |=> urun_flag);

  assert_evt_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |=> !frame_evt);

  assert_evt_in_vsync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |-> !vsync_n);

  assert_stop_exits_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stop_req) |=> (hsync_n && vsync_n && !dotclk_out && busy));

endmodule

bind pix_scan_gen scan_gen_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stop_req   (stop_req),
  .fifo_ready (fifo_ready),
  .fifo_flush (fifo_flush),
  .dotclk_out (dotclk_out),
  .hsync_n    (hsync_n),
  .vsync_n    (vsync_n),
  .pix_data   (pix_data),
  .frame_evt  (frame_evt),
  .urun_flag  (urun_flag),
  .urun_clr   (urun_clr),
  .busy       (busy)
);

// File: tb/tb_pix_scan_gen.sv
module tb_pix_scan_gen;

  localparam int CLK_PERIOD = 10;
  localparam int DW      = 8;
  localparam int H_PIX   = 4;
  localparam int H_SYNC  = 2;
  localparam int H_BACK  = 3;
  localparam int H_FRONT = 4;
  localparam int V_LINES = 3;
  localparam int V_SYNC  = 1;
  localparam int V_BACK  = 2;
  localparam int V_FRONT = 1;
  localparam int H_TOT   = H_SYNC + H_BACK + 3 * H_PIX + H_FRONT;
  localparam int V_TOT   = V_SYNC + V_BACK + V_LINES + V_FRONT;
  localparam int F_TOT   = H_TOT * V_TOT;
  localparam int H_A0    = H_SYNC + H_BACK;
  localparam int H_A1    = H_A0 + 3 * H_PIX;
  localparam int V_A0    = V_SYNC + V_BACK;
  localparam int V_A1    = V_A0 + V_LINES;
  localparam int BIG     = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_req = 1'b0;
  logic          stop_req = 1'b0;
  logic          urun_clr = 1'b0;
  logic [DW-1:0] fifo_data;
  logic          fifo_valid;
  logic          fifo_ready, fifo_flush, dotclk_out, hsync_n, vsync_n;
  logic [DW-1:0] pix_data;
  logic          frame_evt, urun_flag, busy;

  int src_idx = 0;
  int src_limit = 0;
  int n_checks = 0;
  int n_err = 0;
  bit exp_flag = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 37 + 11);
  endfunction

  assign fifo_data  = pat(src_idx);
  assign fifo_valid = (src_idx < src_limit);

  always @(posedge clk) begin
    if (fifo_flush) src_idx <= 0;
    else if (fifo_valid && fifo_ready) src_idx <= src_idx + 1;
  end

  pix_scan_gen #(
    .DW(DW), .BYTES_PER_PIX(3), .H_PIX(H_PIX), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .H_FRONT(H_FRONT), .V_LINES(V_LINES), .V_SYNC(V_SYNC), .V_BACK(V_BACK),
    .V_FRONT(V_FRONT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .fifo_data(fifo_data), .fifo_valid(fifo_valid), .fifo_ready(fifo_ready),
    .fifo_flush(fifo_flush), .dotclk_out(dotclk_out), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .pix_data(pix_data), .frame_evt(frame_evt),
    .urun_flag(urun_flag), .urun_clr(urun_clr), .busy(busy)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Sweep cycle by cycle from a frame start; lim = bytes the source offers.
  task automatic sweep(input int lim, input int ncyc, output bit hit);
    int base, eb, d, loc, h, v;
    bit act;
    hit = 1'b0;
    base = 0;
    eb = 0;
    for (int n = 0; n < ncyc; n++) begin
      @(negedge clk);
      if (n == 0) begin
        start_req = 1'b0;
        base = src_idx;
        src_limit = base + lim;
      end
      d   = n / 2;
      loc = d % F_TOT;
      h   = loc % H_TOT;
      v   = loc / H_TOT;
      act = (h >= H_A0) && (h < H_A1) && (v >= V_A0) && (v < V_A1);
      if ((n % 2 == 0) && d > 0 && act) begin
        if (eb == lim) begin
          exp_flag = 1'b1;
          check("R7", "hsync_n in hold", int'(hsync_n), 1);
          check("R7", "vsync_n in hold", int'(vsync_n), 1);
          check("R7", "dotclk in hold", int'(dotclk_out), 0);
          check("R7", "data in hold", int'(pix_data), 0);
          check("R7", "flush in hold", int'(fifo_flush), 1);
          check("R8", "flag set", int'(urun_flag), 1);
          check("R6", "bytes taken at underflow", src_idx - base, lim);
          hit = 1'b1;
          return;
        end
        eb++;
      end
      check("R2", "dotclk", int'(dotclk_out), n % 2);
      check("R3", "hsync_n", int'(hsync_n), (h < H_SYNC) ? 0 : 1);
      check("R4", "vsync_n", int'(vsync_n), (v < V_SYNC) ? 0 : 1);
      if (act) check("R5", "pixel byte", int'(pix_data), int'(pat(base + eb - 1)));
      else     check("R6", "blank byte", int'(pix_data), 0);
      check("R6", "bytes taken", src_idx - base, eb);
      check("R9", "frame_evt", int'(frame_evt), (n % (2 * F_TOT) == 0) ? 1 : 0);
      check("R7", "no flush", int'(fifo_flush), 0);
      check("R8", "flag level", int'(urun_flag), int'(exp_flag));
      check("R11", "busy while scanning", int'(busy), 1);
    end
  endtask

  task automatic do_start();
    start_req = 1'b1;
    @(posedge clk);
  endtask

  // Called right after a negedge sample.
  task automatic do_stop(input int k);
    int s0;
    stop_req = 1'b1;
    s0 = src_idx;
    src_limit = s0 + k;
    @(posedge clk);
    @(negedge clk);
    stop_req = 1'b0;
    check("R10", "busy after stop", int'(busy), 1);
    check("R10", "hsync_n after stop", int'(hsync_n), 1);
    check("R10", "vsync_n after stop", int'(vsync_n), 1);
    check("R10", "dotclk after stop", int'(dotclk_out), 0);
    check("R10", "ready in drain", int'(fifo_ready), 1);
    check("R10", "nothing taken at stop", src_idx, s0);
    for (int j = 1; j <= k; j++) begin
      @(negedge clk);
      check("R10", "busy while draining", int'(busy), 1);
      check("R10", "drained count", src_idx, s0 + j);
    end
    @(negedge clk);
    check("R10", "busy after drain", int'(busy), 0);
    check("R1", "ready when idle", int'(fifo_ready), 0);
    check("R10", "final drained count", src_idx, s0 + k);
  endtask

  initial begin
    bit hit;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R1", "hsync_n idle", int'(hsync_n), 1);
    check("R1", "vsync_n idle", int'(vsync_n), 1);
    check("R1", "dotclk idle", int'(dotclk_out), 0);
    check("R1", "data idle", int'(pix_data), 0);
    check("R1", "busy idle", int'(busy), 0);
    check("R1", "flag idle", int'(urun_flag), 0);
    check("R1", "evt idle", int'(frame_evt), 0);
    check("R1", "flush idle", int'(fifo_flush), 0);

    // Two full frames with a full source, across the frame wrap.
    do_start();
    sweep(BIG, 4 * F_TOT, hit);
    check("R5", "no underflow with full source", int'(hit), 0);
    do_stop(3);

    // Stop in idle has no effect; stop wins over start.
    stop_req = 1'b1;
    start_req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    stop_req = 1'b0;
    start_req = 1'b0;
    check("R10", "stop beats start", int'(busy), 0);

    // Empty source: blanking passes, first visible byte underflows.
    do_start();
    sweep(0, 2 * F_TOT, hit);
    check("R7", "underflow at first byte", int'(hit), 1);
    // Restarted frame; source ends one byte into the second line.
    sweep(13, 2 * F_TOT, hit);
    check("R7", "underflow past line end", int'(hit), 1);
    sweep(BIG, 2 * F_TOT + 2, hit);
    check("R7", "clean frame after recovery", int'(hit), 0);

    // Clear the sticky flag.
    urun_clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    urun_clr = 1'b0;
    exp_flag = 1'b0;
    check("R8", "flag cleared", int'(urun_flag), 0);
    @(negedge clk);
    check("R8", "flag stays clear", int'(urun_flag), 0);
    do_stop(0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule